// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers thirty-two level-sensitive interrupt lines and steers each one to one of two processor inputs: a normal interrupt request and a fast interrupt request. Each line has an enable bit and a route bit. The enable bit gates the line away from both outputs. The route bit chooses which output the line reaches. The lines pass through one register stage before any logic sees them. Software then reads the raw captured levels, and it can also read two filtered views, one for each output.

A single control bit decides how the idle-wake output qualifies its sources. With the bit clear, any captured line wakes the core whether it is enabled or not. With the bit set, only enabled lines wake it. Lines are never acknowledged inside the block: a request stays pending until the peripheral drops its line. A lowest-index encoder over the normal-request view gives a dispatch helper the number of the line to service next.

There is no state machine. The behaviour rests on three held registers: enable, route and wake control. Around them sit one capture stage, a combinational read multiplexer, registered request outputs and a combinational vector encoder.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset the enable, route and wake-control registers read 0, and irq_o, fiq_o and wake_o are 0.
- R2: Offset 0x20 reads the source levels that were captured on the previous clock edge, with bit n holding source n.
- R3: Offset 0x00 (normal view) reads raw & enable & ~route. A line with enable 0 reaches neither output.
- R4: Offset 0x10 (fast view) reads raw & enable & route. A route bit of 1 selects the fast output and a route bit of 0 selects the normal output.
- R5: irq_o is the OR of the normal view, registered, so it rises on the second clock edge after a source rises.
- R6: fiq_o is the OR of the fast view, registered with the same timing as irq_o.
- R7: With wake-control bit 0 clear, wake_o is 1 one edge after any raw bit is 1, whether that bit is enabled or not.
- R8: With wake-control bit 0 set, wake_o is 1 only when some raw bit with enable 1 is set. The route bit plays no part in this.
- R9: Writes to 0x00, 0x10 and 0x20 change nothing. Reads of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x20 return 0.
- R10: vec_idx gives the lowest set bit of the normal view and vec_valid is 1 when that view is non-zero. When the view is zero, vec_idx is 0 and vec_valid is 0.
- R11: A pending line clears with no acknowledge: two edges after the source drops, the views and the outputs are clear again.
- R12: Offset 0x04 (enable) and offset 0x08 (route) read back the last 32-bit value written to them. Offset 0x0C stores only bit 0 and reads 0 in bits 31..1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level interrupt lines, one per source |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle-wake request |
| vec_idx | output | 5 | Lowest active normal-request index |
| vec_valid | output | 1 | vec_idx is meaningful |

## Verification
A source change is visible in the raw, normal and fast read views and on vec_idx one edge after it is applied. irq_o, fiq_o and wake_o follow one edge later. A register write takes effect at the edge that takes it, so the outputs that depend on it move one edge after that. The bench drives inputs on the falling edge and holds them across two rising edges before it samples anything. It reads results one time unit after a falling edge. A dedicated timing test samples between the two edges to confirm that the views have moved while irq_o has not yet.

// File: rtl/dic_pkg.sv
package dic_pkg;
    localparam logic [7:0] OFF_IRQ_VIEW = 8'h00;
    localparam logic [7:0] OFF_ENABLE   = 8'h04;
    localparam logic [7:0] OFF_ROUTE    = 8'h08;
    localparam logic [7:0] OFF_WAKECTL  = 8'h0C;
    localparam logic [7:0] OFF_FIQ_VIEW = 8'h10;
    localparam logic [7:0] OFF_RAW      = 8'h20;
endpackage

// File: rtl/dic_sample.sv
module dic_sample #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    output logic [N_SRC-1:0] raw_q
);
    // one capture flop per source line
    for (genvar g = 0; g < N_SRC; g++) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) raw_q[g] <= 1'b0;
            else        raw_q[g] <= src_i[g];
        end
    end
endmodule

// File: rtl/dic_regs.sv
module dic_regs
    import dic_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [N_SRC-1:0]  bus_wdata,
    input  logic [N_SRC-1:0]  raw_q,
    input  logic [N_SRC-1:0]  irq_pend,
    input  logic [N_SRC-1:0]  fiq_pend,
    output logic [N_SRC-1:0]  mask_q,
    output logic [N_SRC-1:0]  level_q,
    output logic              ctrl_q,
    output logic [N_SRC-1:0]  bus_rdata
);
    logic hit_mask, hit_level, hit_ctrl;

    assign hit_mask  = (bus_addr == ADDR_W'(OFF_ENABLE));
    assign hit_level = (bus_addr == ADDR_W'(OFF_ROUTE));
    assign hit_ctrl  = (bus_addr == ADDR_W'(OFF_WAKECTL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            level_q <= '0;
            ctrl_q  <= 1'b0;
        end else if (bus_we) begin
            if (hit_mask)  mask_q  <= bus_wdata;
            if (hit_level) level_q <= bus_wdata;
            if (hit_ctrl)  ctrl_q  <= bus_wdata[0];
        end
    end

    // pending offsets have no write path; unmapped offsets read zero
    always_comb begin
        bus_rdata = '0;
        if      (bus_addr == ADDR_W'(OFF_IRQ_VIEW)) bus_rdata = irq_pend;
        else if (hit_mask)                          bus_rdata = mask_q;
        else if (hit_level)                         bus_rdata = level_q;
        else if (hit_ctrl)                          bus_rdata = N_SRC'(ctrl_q);
        else if (bus_addr == ADDR_W'(OFF_FIQ_VIEW)) bus_rdata = fiq_pend;
        else if (bus_addr == ADDR_W'(OFF_RAW))      bus_rdata = raw_q;
    end
endmodule

// File: rtl/dic_route.sv
module dic_route #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] raw_q,
    input  logic [N_SRC-1:0] mask_q,
    input  logic [N_SRC-1:0] level_q,
    input  logic             ctrl_q,
    output logic [N_SRC-1:0] irq_pend,
    output logic [N_SRC-1:0] fiq_pend,
    output logic             irq_o,
    output logic             fiq_o,
    output logic             wake_o
);
    logic [N_SRC-1:0] live;
    logic [N_SRC-1:0] wake_src;

    for (genvar g = 0; g < N_SRC; g++) begin : g_steer
        assign live[g]     = raw_q[g] & mask_q[g];
        assign irq_pend[g] = live[g] & ~level_q[g];
        assign fiq_pend[g] = live[g] &  level_q[g];
        assign wake_src[g] = ctrl_q ? live[g] : raw_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            fiq_o  <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            irq_o  <= |irq_pend;
            fiq_o  <= |fiq_pend;
            wake_o <= |wake_src;
        end
    end
endmodule

// File: rtl/dic_vector.sv
module dic_vector #(
    parameter int N_SRC = 32,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] pend,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);
    always_comb begin
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
        valid = |pend;
    end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              wake_o,
    output logic [IDX_W-1:0]  vec_idx,
    output logic              vec_valid
);
    logic [N_SRC-1:0] raw_q, mask_q, level_q, irq_pend, fiq_pend;
    logic             ctrl_q;

    dic_sample #(.N_SRC(N_SRC)) u_sample (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .raw_q(raw_q)
    );

    dic_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .raw_q(raw_q), .irq_pend(irq_pend),
        .fiq_pend(fiq_pend), .mask_q(mask_q), .level_q(level_q),
        .ctrl_q(ctrl_q), .bus_rdata(bus_rdata)
    );

    dic_route #(.N_SRC(N_SRC)) u_route (
        .clk(clk), .rst_n(rst_n), .raw_q(raw_q), .mask_q(mask_q),
        .level_q(level_q), .ctrl_q(ctrl_q), .irq_pend(irq_pend),
        .fiq_pend(fiq_pend), .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
    );

    dic_vector #(.N_SRC(N_SRC)) u_vector (
        .pend(irq_pend), .idx(vec_idx), .valid(vec_valid)
    );
endmodule

// File: rtl/dual_irq_ctrl_chk.sv
module dual_irq_ctrl_chk #(
    parameter int N_SRC = 32,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] raw_q,
    input logic [N_SRC-1:0] mask_q,
    input logic [N_SRC-1:0] level_q,
    input logic             ctrl_q,
    input logic [N_SRC-1:0] irq_pend,
    input logic             irq_o,
    input logic             fiq_o,
    input logic             wake_o,
    input logic [IDX_W-1:0] vec_idx,
    input logic             vec_valid
);
    // R3: an all-zero enable keeps both outputs quiet
    a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask_q) == '0) |-> (!irq_o && !fiq_o));

    // R4: all lines routed fast leaves the normal output quiet
    a_r4_route_fast: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(&level_q)) |-> !irq_o);

    // R6: all lines routed normal leaves the fast output quiet
    a_r6_route_normal: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(level_q) == '0) |-> !fiq_o);

    // R8: qualified wake needs an enabled raw line
    a_r8_wake_qual: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_q) && ($past(raw_q & mask_q) == '0)) |-> !wake_o);

    // R7: an unqualified wake follows any raw line
    a_r7_wake_any: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctrl_q) && ($past(raw_q) != '0)) |-> wake_o);

    // R10: the encoded index points at a set bit with nothing set below it
    a_r10_vec_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (irq_pend[vec_idx] &&
            ((irq_pend & ((N_SRC'(1) << vec_idx) - N_SRC'(1))) == '0)));

    // R10: with no valid vector the index rests at zero
    a_r10_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_idx == '0 && irq_pend == '0));
endmodule

bind dual_irq_ctrl dual_irq_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .raw_q(raw_q), .mask_q(mask_q),
    .level_q(level_q), .ctrl_q(ctrl_q), .irq_pend(irq_pend),
    .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o),
    .vec_idx(vec_idx), .vec_valid(vec_valid)
);

// File: tb/dual_irq_ctrl_bench.sv
`timescale 1ns/1ps
module dual_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o, wake_o, vec_valid;
    logic [4:0]  vec_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_irq_ctrl u_dual_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o),
        .vec_idx(vec_idx), .vec_valid(vec_valid)
    );

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] en;
        logic [31:0] rt;
        logic        wk;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
        '{32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 1'b1},
        '{32'h0000_F000, 32'h0000_0000, 32'h0000_0000, 1'b0},
        '{32'h0000_F000, 32'h0000_0000, 32'h0000_0000, 1'b1},
        '{32'hA5A5_0000, 32'hFF00_FF00, 32'h0F0F_0F0F, 1'b1},
        '{32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 1'b1},
        '{32'h0010_0800, 32'hFFFF_FFFF, 32'h0000_0800, 1'b0},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [5:0] lowest(input logic [31:0] v);
        logic [5:0] r = 6'd0;
        for (int i = 31; i >= 0; i--) if (v[i]) r = 6'(i);
        return r;
    endfunction

    initial begin
        #(5ns * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] ip, fp;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(8'h04, r); check("R1 enable reset", r, 32'h0);
        rd(8'h08, r); check("R1 route reset", r, 32'h0);
        rd(8'h0C, r); check("R1 wakectl reset", r, 32'h0);
        check("R1 outputs reset", {29'd0, irq_o, fiq_o, wake_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // table walk: R2 R3 R4 R5 R6 R7 R8 R10 R12
        for (int i = 0; i < 8; i++) begin
            wr(8'h04, VECS[i].en);
            wr(8'h08, VECS[i].rt);
            wr(8'h0C, {31'd0, VECS[i].wk});
            src_i = VECS[i].src;
            @(negedge clk); @(negedge clk);
            ip = VECS[i].src & VECS[i].en & ~VECS[i].rt;
            fp = VECS[i].src & VECS[i].en & VECS[i].rt;
            rd(8'h20, r); check("R2 raw view", r, VECS[i].src);
            rd(8'h00, r); check("R3 normal view", r, ip);
            rd(8'h10, r); check("R4 fast view", r, fp);
            rd(8'h04, r); check("R12 enable readback", r, VECS[i].en);
            rd(8'h08, r); check("R12 route readback", r, VECS[i].rt);
            check("R5 irq_o", {31'd0, irq_o}, {31'd0, |ip});
            check("R6 fiq_o", {31'd0, fiq_o}, {31'd0, |fp});
            if (VECS[i].wk)
                check("R8 wake qualified", {31'd0, wake_o}, {31'd0, |(VECS[i].src & VECS[i].en)});
            else
                check("R7 wake any", {31'd0, wake_o}, {31'd0, |VECS[i].src});
            check("R10 vec_valid", {31'd0, vec_valid}, {31'd0, |ip});
            check("R10 vec_idx", {27'd0, vec_idx}, (|ip) ? {26'd0, lowest(ip)} : 32'd0);
        end

        // R9: pending offsets ignore writes; unmapped reads zero
        src_i = '0;
        wr(8'h04, 32'h0000_00FF);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(8'h00, r); check("R9 normal view unwritable", r, 32'h0);
        rd(8'h10, r); check("R9 fast view unwritable", r, 32'h0);
        rd(8'h20, r); check("R9 raw view unwritable", r, 32'h0);
        rd(8'h04, r); check("R9 enable untouched", r, 32'h0000_00FF);
        check("R9 no request", {30'd0, irq_o, fiq_o}, 32'h0);
        rd(8'h14, r); check("R9 unmapped 0x14", r, 32'h0);
        rd(8'h24, r); check("R9 unmapped 0x24", r, 32'h0);

        // R12: control keeps only bit 0
        wr(8'h0C, 32'hFFFF_FFFE);
        rd(8'h0C, r); check("R12 wakectl bit0 clear", r, 32'h0);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, r); check("R12 wakectl bit0 only", r, 32'h1);

        // R5 timing: views after one edge, irq_o after two
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h08, 32'h0);
        @(negedge clk);
        src_i = 32'h0000_0040;
        @(negedge clk);
        rd(8'h00, r); check("R5 view after one edge", r, 32'h0000_0040);
        check("R5 irq_o not yet", {31'd0, irq_o}, 32'h0);
        check("R10 vec_idx six", {27'd0, vec_idx}, 32'd6);
        @(negedge clk);
        check("R5 irq_o after two edges", {31'd0, irq_o}, 32'h1);

        // R11: drop the line, no acknowledge
        src_i = '0;
        @(negedge clk); @(negedge clk);
        rd(8'h00, r); check("R11 view clears", r, 32'h0);
        check("R11 irq_o clears", {31'd0, irq_o}, 32'h0);
        check("R11 vec_valid clears", {31'd0, vec_valid}, 32'h0);

        // R1: reset in the middle of activity
        src_i = 32'h0000_0003;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b0;
        #1;
        rd(8'h04, r); check("R1 enable after reset", r, 32'h0);
        check("R1 outputs after reset", {29'd0, irq_o, fiq_o, wake_o}, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule